// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the accumulator datapath of a small 16-bit signal processor. Each cycle in which the load strobe is high, it applies one of six operation classes to a 32-bit accumulator: subtract, compare, add, AND, OR or XOR. It also updates a set of four status flags. The operands arrive already read. One is a half-width value taken from the register file. The other is a full-width product value. A select input tells the block which of the two is the source.

The source sets the width of the operation. With the half-width source, add, subtract and compare act only on the upper half of the accumulator, and the lower half is left untouched. The logical operations place the operand in the upper half, fill the lower half with zeros, and combine the result with the whole accumulator. With the product source, the same opcode becomes a full 32-bit operation. Compare only sets the flags. The zero and negative flags follow the result. The carry-like flag and the overflow flag are cleared by every operation and never set.

Top module: `aam_acc_alu`

## Requirements
- R1: After reset, the accumulator is zero and all four flags (zero, negative, carry-like, overflow) are low.
- R2: While the load strobe is low, the accumulator and all flags keep their values.
- R3: The opcode field encodes subtract as 0x1, compare as 0x3, add as 0x4, AND as 0x5, OR as 0x6 and XOR as 0x7. Any other value leaves the accumulator and the flags unchanged, even when the load strobe is high.
- R4: With the half-width source, add and subtract combine the operand with the accumulator's upper half modulo 2^16. The result is written to the upper half, and the lower half is kept.
- R5: With the half-width source, AND, OR and XOR combine the operand shifted left by 16 (lower half zero) with the whole accumulator. A half-width AND therefore clears the lower half.
- R6: With the product source selected, every class operates on the full 32-bit accumulator and the 32-bit product value, modulo 2^32.
- R7: Compare computes the subtraction and updates the flags, but never changes the accumulator.
- R8: The zero flag is set exactly when the result is zero. For half-width add, subtract and compare, the result is the 16-bit upper-half result. For every other case it is the 32-bit result.
- R9: The negative flag equals the result's top bit: bit 15 of a 16-bit result, or bit 31 of a 32-bit result. It is low whenever the zero flag is set.
- R10: The carry-like flag and the overflow flag are low after every operation and are never set.
- R11: The results of an operation appear on the outputs on the clock edge that samples the load strobe high. The accumulator and the flags change on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | One-cycle strobe that commits the operation |
| opc | input | 4 | Operation class (upper opcode nibble) |
| prod_sel | input | 1 | High: the source is the product value (32-bit mode) |
| opnd | input | 16 | Half-width operand |
| prod | input | 32 | Product-register operand |
| acc | output | 32 | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_l | output | 1 | Carry-like flag, always cleared |
| flag_v | output | 1 | Overflow flag, always cleared |

## Verification
The assertions check on every cycle that the state holds while no load is applied. They also check that compare and undefined classes leave the accumulator unchanged, and that half-width add and subtract preserve the lower half. Further per-cycle checks: a half-width AND zeroes the lower half, the zero and negative flags are never both set, the two cleared flags stay low, and after a 32-bit write the zero flag matches the accumulator. The exact arithmetic values, the wrap-around of the upper half, and a zero flag raised while the lower half is still nonzero can only be shown by the bench. It runs directed sequences and a long random run against a behavioural model.

// File: rtl/aam_pkg.sv
package aam_pkg;

   typedef enum logic [3:0] {
      OPC_SUB = 4'h1,
      OPC_CMP = 4'h3,
      OPC_ADD = 4'h4,
      OPC_AND = 4'h5,
      OPC_OR  = 4'h6,
      OPC_XOR = 4'h7
   } opc_e;

   typedef enum logic [2:0] {
      FN_NONE,
      FN_ADD,
      FN_SUB,
      FN_AND,
      FN_OR,
      FN_XOR
   } fn_e;

   typedef struct packed {
      logic l;
      logic z;
      logic v;
      logic n;
   } flags_t;

   function automatic fn_e decode_fn(input logic [3:0] code);
      case (code)
         OPC_SUB, OPC_CMP: decode_fn = FN_SUB;
         OPC_ADD:          decode_fn = FN_ADD;
         OPC_AND:          decode_fn = FN_AND;
         OPC_OR:           decode_fn = FN_OR;
         OPC_XOR:          decode_fn = FN_XOR;
         default:          decode_fn = FN_NONE;
      endcase
   endfunction

endpackage

// File: rtl/aam_opnd_align.sv
module aam_opnd_align #(
   parameter int HALF_W = 16,
   localparam int ACC_W = 2 * HALF_W
) (
   input  logic              wide_mode,
   input  logic              arith_op,
   input  logic [ACC_W-1:0]  acc_cur,
   input  logic [HALF_W-1:0] opnd,
   input  logic [ACC_W-1:0]  prod,
   output logic [ACC_W-1:0]  lhs,
   output logic [ACC_W-1:0]  rhs
);
   // Half-width arithmetic runs in the upper lane with a zero lower lane,
   // so one wide datapath serves both modes.
   always_comb begin
      if (wide_mode) begin
         lhs = acc_cur;
         rhs = prod;
      end else begin
         rhs = {opnd, {HALF_W{1'b0}}};
         lhs = arith_op ? {acc_cur[ACC_W-1:HALF_W], {HALF_W{1'b0}}} : acc_cur;
      end
   end
endmodule

// File: rtl/aam_arith.sv
module aam_arith
   import aam_pkg::*;
#(
   parameter int W        = 32,
   parameter int SUB_IMPL = 0
) (
   input  fn_e          fn,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res
);
   logic [W-1:0] diff;

   generate
      if (SUB_IMPL == 0) begin : g_sub_native
         assign diff = a - b;
      end else begin : g_sub_invert
         assign diff = a + ~b + {{(W-1){1'b0}}, 1'b1};
      end
   endgenerate

   always_comb begin
      case (fn)
         FN_ADD:  res = a + b;
         FN_SUB:  res = diff;
         FN_AND:  res = a & b;
         FN_OR:   res = a | b;
         FN_XOR:  res = a ^ b;
         default: res = a;
      endcase
   end
endmodule

// File: rtl/aam_flag_eval.sv
module aam_flag_eval
   import aam_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] res,
   output flags_t       flg
);
   logic is_zero;
   assign is_zero = (res == '0);

   always_comb begin
      flg   = '0;
      flg.z = is_zero;
      flg.n = ~is_zero & res[W-1];
   end
endmodule

// File: rtl/aam_acc_alu.sv
module aam_acc_alu
   import aam_pkg::*;
#(
   parameter int HALF_W   = 16,
   parameter int OPC_W    = 4,
   parameter int SUB_IMPL = 0,
   localparam int ACC_W   = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [OPC_W-1:0]  opc,
   input  logic              prod_sel,
   input  logic [HALF_W-1:0] opnd,
   input  logic [ACC_W-1:0]  prod,
   output logic [ACC_W-1:0]  acc,
   output logic              flag_z,
   output logic              flag_n,
   output logic              flag_l,
   output logic              flag_v
);
   generate
      if (HALF_W < 2) begin : g_bad_width
         $error("aam_acc_alu: HALF_W must be at least 2");
      end
      if (OPC_W != 4) begin : g_bad_opc
         $error("aam_acc_alu: OPC_W must be 4");
      end
      if (SUB_IMPL != 0 && SUB_IMPL != 1) begin : g_bad_sub
         $error("aam_acc_alu: SUB_IMPL must be 0 or 1");
      end
   endgenerate

   fn_e              fn;
   logic             is_cmp;
   logic             arith_op;
   logic             do_write;
   logic [ACC_W-1:0] lhs, rhs, res, acc_nxt;
   flags_t           flg_nxt, flg_q;

   assign fn       = decode_fn(opc);
   assign is_cmp   = (opc == OPC_CMP);
   assign arith_op = (fn == FN_ADD) || (fn == FN_SUB);
   assign do_write = ld_en && (fn != FN_NONE);

   aam_opnd_align #(.HALF_W(HALF_W)) u_align (
      .wide_mode (prod_sel),
      .arith_op  (arith_op),
      .acc_cur   (acc),
      .opnd      (opnd),
      .prod      (prod),
      .lhs       (lhs),
      .rhs       (rhs)
   );

   aam_arith #(.W(ACC_W), .SUB_IMPL(SUB_IMPL)) u_arith (
      .fn  (fn),
      .a   (lhs),
      .b   (rhs),
      .res (res)
   );

   aam_flag_eval #(.W(ACC_W)) u_flags (
      .res (res),
      .flg (flg_nxt)
   );

   always_comb begin
      if (is_cmp)
         acc_nxt = acc;
      else if (arith_op && !prod_sel)
         acc_nxt = {res[ACC_W-1:HALF_W], acc[HALF_W-1:0]};
      else
         acc_nxt = res;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc   <= '0;
         flg_q <= '0;
      end else if (do_write) begin
         acc   <= acc_nxt;
         flg_q <= flg_nxt;
      end
   end

   assign flag_z = flg_q.z;
   assign flag_n = flg_q.n;
   assign flag_l = flg_q.l;
   assign flag_v = flg_q.v;
endmodule

// File: rtl/aam_acc_alu_chk.sv
module aam_acc_alu_chk #(
   parameter int HALF_W = 16,
   localparam int ACC_W = 2 * HALF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_en,
   input logic [3:0]        opc,
   input logic              prod_sel,
   input logic [HALF_W-1:0] opnd,
   input logic [ACC_W-1:0]  prod,
   input logic [ACC_W-1:0]  acc,
   input logic              flag_z,
   input logic              flag_n,
   input logic              flag_l,
   input logic              flag_v
);
   logic valid_cls;
   assign valid_cls = (opc == 4'h1) || (opc == 4'h3) || (opc == 4'h4) ||
                      (opc == 4'h5) || (opc == 4'h6) || (opc == 4'h7);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> $stable(acc) && $stable(flag_z) && $stable(flag_n));

   // R3
   bad_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !valid_cls) |=> $stable(acc) && $stable(flag_z) && $stable(flag_n));

   // R7
   cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && opc == 4'h3) |=> $stable(acc));

   // R4
   low_half_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !prod_sel && (opc == 4'h1 || opc == 4'h4))
      |=> acc[HALF_W-1:0] == $past(acc[HALF_W-1:0]));

   // R5
   and_clears_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !prod_sel && opc == 4'h5) |=> acc[HALF_W-1:0] == '0);

   // R9
   z_n_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_z |-> !flag_n);

   // R10
   l_v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_l && !flag_v);

   // R8
   wide_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && prod_sel && valid_cls && opc != 4'h3) |=> flag_z == (acc == '0));
endmodule

bind aam_acc_alu aam_acc_alu_chk #(.HALF_W(HALF_W)) u_chk (.*);

// File: tb/tb_aam_acc_alu.sv
`timescale 1ns/1ps
module tb_aam_acc_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0;
   logic [3:0]  opc = 4'h0;
   logic        prod_sel = 1'b0;
   logic [15:0] opnd = 16'h0;
   logic [31:0] prod = 32'h0;
   logic [31:0] acc;
   logic        flag_z, flag_n, flag_l, flag_v;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit live = 1'b0;

   always #2 clk = ~clk;

   aam_acc_alu dut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .opc(opc), .prod_sel(prod_sel),
      .opnd(opnd), .prod(prod), .acc(acc), .flag_z(flag_z), .flag_n(flag_n),
      .flag_l(flag_l), .flag_v(flag_v)
   );

   // Behavioural reference model
   logic [31:0] m_acc = 32'h0;
   bit m_z = 1'b0, m_n = 1'b0;
   always @(posedge clk) begin
      logic [31:0] r;
      logic [15:0] h;
      if (!rst_n) begin
         m_acc = 32'h0; m_z = 1'b0; m_n = 1'b0;
      end else if (ld_en) begin
         case (opc)
            4'h1, 4'h3, 4'h4: begin
               if (prod_sel) begin
                  r = (opc == 4'h4) ? m_acc + prod : m_acc - prod;
                  m_z = (r == 0); m_n = r[31];
                  if (opc != 4'h3) m_acc = r;
               end else begin
                  h = (opc == 4'h4) ? m_acc[31:16] + opnd : m_acc[31:16] - opnd;
                  m_z = (h == 0); m_n = h[15];
                  if (opc != 4'h3) m_acc[31:16] = h;
               end
            end
            4'h5, 4'h6, 4'h7: begin
               r = prod_sel ? prod : {opnd, 16'h0};
               if (opc == 4'h5) m_acc = m_acc & r;
               else if (opc == 4'h6) m_acc = m_acc | r;
               else m_acc = m_acc ^ r;
               m_z = (m_acc == 0); m_n = m_acc[31];
            end
            default: ;
         endcase
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // R11: per-cycle comparison against the model
   always @(negedge clk) begin
      if (live && !done) begin
         chk("R11 acc", acc, m_acc);
         chk("R8 zero", {31'h0, flag_z}, {31'h0, m_z});
         chk("R9 neg", {31'h0, flag_n}, {31'h0, m_n});
         chk("R10 l/v", {30'h0, flag_l, flag_v}, 32'h0);
      end
   end

   task automatic op(input logic [3:0] c, input logic s, input logic [15:0] d, input logic [31:0] p);
      @(negedge clk);
      opc = c; prod_sel = s; opnd = d; prod = p; ld_en = 1'b1;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic st(input string req, input logic [31:0] ea, input bit ez, input bit en);
      chk(req, acc, ea);
      chk(req, {30'h0, flag_z, flag_n}, {30'h0, ez, en});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      live = 1'b1;
      st("R1 reset", 32'h0, 1'b0, 1'b0);
      chk("R1 l/v", {30'h0, flag_l, flag_v}, 32'h0);

      op(4'h4, 1'b0, 16'h1234, 32'h0);       st("R4 add16", 32'h12340000, 0, 0);
      op(4'h1, 1'b0, 16'h2000, 32'h0);       st("R4 sub16 wrap", 32'hF2340000, 0, 1);
      op(4'h4, 1'b1, 16'h0, 32'h0DCC0005);   st("R6 add32", 32'h00000005, 0, 0);
      op(4'h4, 1'b0, 16'h0001, 32'h0);       st("R4 low kept", 32'h00010005, 0, 0);
      op(4'h1, 1'b0, 16'h0001, 32'h0);       st("R8 zero on upper", 32'h00000005, 1, 0);
      op(4'h3, 1'b0, 16'h0001, 32'h0);       st("R7 cmp16", 32'h00000005, 0, 1);
      op(4'h6, 1'b0, 16'h8000, 32'h0);       st("R5 or16", 32'h80000005, 0, 1);
      op(4'h5, 1'b0, 16'hFFFF, 32'h0);       st("R5 and16", 32'h80000000, 0, 1);
      op(4'h7, 1'b0, 16'h8000, 32'h0);       st("R8 xor zero", 32'h0, 1, 0);
      op(4'h1, 1'b1, 16'h0, 32'h00000001);   st("R6 sub32", 32'hFFFFFFFF, 0, 1);
      op(4'h3, 1'b1, 16'h0, 32'hFFFFFFFF);   st("R7 cmp32", 32'hFFFFFFFF, 1, 0);
      op(4'h5, 1'b1, 16'h0, 32'h00F0F00F);   st("R6 and32", 32'h00F0F00F, 0, 0);
      op(4'h2, 1'b0, 16'h5555, 32'h12345678); st("R3 class 2", 32'h00F0F00F, 0, 0);
      op(4'hC, 1'b1, 16'h5555, 32'h12345678); st("R3 class C", 32'h00F0F00F, 0, 0);
      @(negedge clk);
      opc = 4'h4; prod_sel = 1'b1; prod = 32'h1;
      @(negedge clk);
      st("R2 no load", 32'h00F0F00F, 0, 0);

      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         opc = 4'($urandom_range(0, 8));
         prod_sel = 1'($urandom);
         opnd = 16'($urandom);
         prod = (i % 7 == 0) ? acc : $urandom;
         ld_en = 1'($urandom_range(0, 3) != 0);
      end
      @(negedge clk);
      ld_en = 1'b0;
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule